// File: doc/BRIEF.md
# User-Definable Glyph Pattern Store

This block is the writable glyph memory of a character display controller. It holds a small set of user-drawn characters, eight glyphs of eight rows each, one byte per row. A byte-wide write port loads rows by a 6-bit pattern address. The upper three bits of that address pick the glyph and the lower three bits pick the row. A separate byte read port returns any stored byte in full, so the three data bits that never reach the screen can serve as general scratch storage.

The pixel path takes a character code, a row index and a cursor-enable flag, and returns the 5-pixel slice for that row. Only codes below 0x10 are served here. For those codes the block raises a hit flag. Bit 3 of the code plays no part, so each glyph answers to two codes. Rows 0 to 6 carry the glyph image. Row 7 is the cursor line: any one stored in it always lights that pixel, and an asserted cursor-enable lights the whole line. For codes of 0x10 and above the hit flag stays low and the pixels are zero, so a fixed font path outside this block can take over. All outputs are registered and appear one cycle after their inputs.

Top module: `glyph_pattern_store`

## Requirements
- R1: The store holds 64 bytes at pattern addresses 0..63. A write with `wr_en`=1 lands on the rising clock edge. A read on the byte port returns all 8 bits of `rd_addr` on `rd_data` one cycle after the address is presented.
- R2: When the byte port reads the address being written in the same cycle, it returns the data held before that write. The new data is returned from the next cycle on.
- R3: For a code in 0x00..0x0F, `px_bits` one cycle later equals bits [4:0] of the byte at pattern address {code[2:0], px_row}. Code bits [2:0] form address bits [5:3] and the row forms address bits [2:0].
- R4: Code bit 3 is ignored. Code 0x07 gives the same pixels as 0x0F for every row, and likewise for every other pair that differs only in bit 3.
- R5: One cycle after a code, `px_hit` is 1 if the code is in 0x00..0x0F. It is 0 for codes 0x10..0xFF, and for those codes `px_bits` is 0.
- R6: On row 7 of a user code with `px_cursor_en`=1, `px_bits` is 5'b11111.
- R7: On row 7 of a user code with `px_cursor_en`=0, `px_bits` is the stored bits [4:0] of that glyph's row 7. A stored one lights its pixel whatever the cursor state.
- R8: On rows 0..6, `px_cursor_en` has no effect on `px_bits`.
- R9: Data bits [7:5] of a stored byte never change `px_bits`, and they read back unchanged through `rd_data`.
- R10: Synchronous active-high `rst` clears all 64 bytes and the output registers (`px_bits`=0, `px_hit`=0, `rd_data`=0). A write presented during reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one byte |
| wr_addr | input | 6 | Pattern address of the write: {glyph, row} |
| wr_data | input | 8 | Byte to store |
| rd_addr | input | 6 | Pattern address for the byte read port |
| rd_data | output | 8 | Registered byte read result |
| px_code | input | 8 | Character code to render |
| px_row | input | 3 | Row within the glyph (7 = cursor line) |
| px_cursor_en | input | 1 | Cursor visible on this character |
| px_bits | output | 5 | Registered pixel slice for the row |
| px_hit | output | 1 | Registered flag: code is served by this store |

## Verification
Every result of this block is due exactly one rising edge after its inputs. This covers `rd_data` for a byte read, `px_bits`/`px_hit` for a pixel request, and the cleared state after a reset cycle. A write is visible to a read presented one edge later. The bench drives inputs on the falling edge, lets one rising edge pass, and compares on the next falling edge against a model array the bench maintains itself. The read-during-write case is sampled in the same way, once for the old value and again one cycle later for the new value.

// File: rtl/glyph_pkg.sv
package glyph_pkg;

    // Geometry of the user glyph store
    localparam int unsigned ROW_W    = 3;               // row index inside a glyph
    localparam int unsigned GLYPH_W  = 3;               // glyph index
    localparam int unsigned ADDR_W   = GLYPH_W + ROW_W; // pattern address
    localparam int unsigned DEPTH    = 1 << ADDR_W;     // bytes in the store
    localparam int unsigned DATA_W   = 8;               // stored byte
    localparam int unsigned PIX_W    = 5;               // pixels per glyph row
    localparam int unsigned CODE_W   = 8;               // character code
    localparam int unsigned ALIAS_B  = 3;               // ignored code bit
    localparam int unsigned USER_HI  = ALIAS_B + 1;     // lowest bit that must be zero for a user code

    localparam logic [ROW_W-1:0] CURSOR_ROW = '1;       // last row is the cursor line

    typedef logic [ADDR_W-1:0]  paddr_t;
    typedef logic [DATA_W-1:0]  pbyte_t;
    typedef logic [PIX_W-1:0]   pix_t;
    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [ROW_W-1:0]   row_t;
    typedef logic [GLYPH_W-1:0] glyph_t;

    // A decoded pixel request travelling from decoder to row shaper
    typedef struct packed {
        logic   hit;        // code belongs to the user store
        logic   cursor_row; // this is the cursor line
        logic   cursor_en;  // cursor requested on this character
        paddr_t addr;       // pattern address of the row
    } pix_req_t;

    // The registered pixel result
    typedef struct packed {
        logic hit;
        pix_t bits;
    } pix_out_t;

    function automatic logic is_user_code(input code_t code);
        return code[CODE_W-1:USER_HI] == '0;
    endfunction

    function automatic glyph_t glyph_of(input code_t code);
        return code[GLYPH_W-1:0];
    endfunction

    function automatic paddr_t make_addr(input glyph_t g, input row_t r);
        return {g, r};
    endfunction

    // Cursor line: stored ones always lit, enable lights the whole line
    function automatic pix_t shape_row(input pix_t stored, input logic cursor_row,
                                       input logic cursor_en);
        pix_t r;
        r = stored;
        if (cursor_row && cursor_en) begin
            r = '1;
        end
        return r;
    endfunction

endpackage

// File: rtl/glyph_store.sv
module glyph_store
    import glyph_pkg::*;
#(
    parameter int unsigned P_DEPTH  = DEPTH,
    parameter int unsigned P_ADDR_W = ADDR_W,
    parameter int unsigned P_DATA_W = DATA_W,
    parameter int unsigned P_PIX_W  = PIX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [P_ADDR_W-1:0] wr_addr,
    input  logic [P_DATA_W-1:0] wr_data,
    input  logic [P_ADDR_W-1:0] byte_addr,
    output logic [P_DATA_W-1:0] byte_data,
    input  logic [P_ADDR_W-1:0] pix_addr,
    output logic [P_PIX_W-1:0]  pix_data
);

    logic [P_DATA_W-1:0] cells [P_DEPTH];

    // One register per byte; reset wins over a write
    for (genvar i = 0; i < P_DEPTH; i++) begin : g_cell
        logic sel;
        assign sel = wr_en && (wr_addr == P_ADDR_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                cells[i] <= '0;
            end else if (sel) begin
                cells[i] <= wr_data;
            end
        end
    end

    // Both read ports see the contents before this edge's write
    assign byte_data = cells[byte_addr];

    logic [P_DATA_W-1:0] pix_full;
    assign pix_full = cells[pix_addr];
    assign pix_data = pix_full[P_PIX_W-1:0];

    // Upper bits never feed the pixel path
    logic unused_pix_hi;
    assign unused_pix_hi = ^pix_full[P_DATA_W-1:P_PIX_W];

endmodule

// File: rtl/glyph_code_decode.sv
module glyph_code_decode
    import glyph_pkg::*;
(
    input  code_t    code,
    input  row_t     row,
    input  logic     cursor_en,
    output pix_req_t req
);

    // Bit 3 of the code is deliberately left out of the glyph select
    logic unused_alias_bit;
    assign unused_alias_bit = code[ALIAS_B];

    always_comb begin
        req.hit        = is_user_code(code);
        req.cursor_row = (row == CURSOR_ROW);
        req.cursor_en  = cursor_en;
        req.addr       = make_addr(glyph_of(code), row);
    end

endmodule

// File: rtl/glyph_row_shaper.sv
module glyph_row_shaper
    import glyph_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pix_req_t req,
    input  pix_t     stored,
    output pix_out_t out_q
);

    pix_out_t nxt;

    always_comb begin
        nxt.hit  = req.hit;
        nxt.bits = '0;
        if (req.hit) begin
            nxt.bits = shape_row(stored, req.cursor_row, req.cursor_en);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= nxt;
        end
    end

    // Address already consumed by the store
    paddr_t unused_addr;
    assign unused_addr = req.addr;

endmodule

// File: rtl/glyph_pattern_store.sv
module glyph_pattern_store
    import glyph_pkg::*;
#(
    parameter int unsigned P_ADDR_W = ADDR_W,
    parameter int unsigned P_DATA_W = DATA_W,
    parameter int unsigned P_PIX_W  = PIX_W,
    parameter int unsigned P_CODE_W = CODE_W,
    parameter int unsigned P_ROW_W  = ROW_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [P_ADDR_W-1:0] wr_addr,
    input  logic [P_DATA_W-1:0] wr_data,
    input  logic [P_ADDR_W-1:0] rd_addr,
    output logic [P_DATA_W-1:0] rd_data,
    input  logic [P_CODE_W-1:0] px_code,
    input  logic [P_ROW_W-1:0]  px_row,
    input  logic                px_cursor_en,
    output logic [P_PIX_W-1:0]  px_bits,
    output logic                px_hit
);

    localparam int unsigned L_DEPTH = 1 << P_ADDR_W;

    pix_req_t            req;
    pix_t                stored_row;
    logic [P_DATA_W-1:0] byte_now;
    pix_out_t            pix_q;
    logic [P_DATA_W-1:0] rd_q;

    glyph_code_decode u_decode (
        .code      (px_code),
        .row       (px_row),
        .cursor_en (px_cursor_en),
        .req       (req)
    );

    glyph_store #(
        .P_DEPTH  (L_DEPTH),
        .P_ADDR_W (P_ADDR_W),
        .P_DATA_W (P_DATA_W),
        .P_PIX_W  (P_PIX_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .byte_addr (rd_addr),
        .byte_data (byte_now),
        .pix_addr  (req.addr),
        .pix_data  (stored_row)
    );

    glyph_row_shaper u_shaper (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .stored (stored_row),
        .out_q  (pix_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= byte_now;
        end
    end

    assign rd_data = rd_q;
    assign px_bits = pix_q.bits;
    assign px_hit  = pix_q.hit;

endmodule

// File: rtl/glyph_pattern_store_chk.sv
module glyph_pattern_store_chk
    import glyph_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input paddr_t        wr_addr,
    input pbyte_t        wr_data,
    input paddr_t        rd_addr,
    input pbyte_t        rd_data,
    input code_t         px_code,
    input row_t          px_row,
    input logic          px_cursor_en,
    input pix_t          px_bits,
    input logic          px_hit
);

    // R10: a reset cycle leaves every output cleared
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (px_bits == '0 && !px_hit && rd_data == '0));

    // R5: high codes miss and show nothing
    a_r5_high_code_blank: assert property (@(posedge clk) disable iff (rst)
        (px_code[CODE_W-1:USER_HI] != '0) |=> (!px_hit && px_bits == '0));

    // R5: low codes hit
    a_r5_low_code_hit: assert property (@(posedge clk) disable iff (rst)
        (px_code[CODE_W-1:USER_HI] == '0) |=> px_hit);

    // R6: enabled cursor lights the whole cursor line
    a_r6_cursor_full: assert property (@(posedge clk) disable iff (rst)
        (px_code[CODE_W-1:USER_HI] == '0 && px_row == CURSOR_ROW && px_cursor_en)
        |=> (px_bits == '1));

    // R1: a written byte reads back on the next cycle
    a_r1_write_then_read: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && rd_addr == $past(wr_addr))
        |=> (rd_data == $past(wr_data, 2)));

endmodule

bind glyph_pattern_store glyph_pattern_store_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .px_code      (px_code),
    .px_row       (px_row),
    .px_cursor_en (px_cursor_en),
    .px_bits      (px_bits),
    .px_hit       (px_hit)
);

// File: tb/glyph_pattern_store_tb_top.sv
`timescale 1ns/100ps
module glyph_pattern_store_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [5:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [7:0] px_code = '0;
    logic [2:0] px_row = '0;
    logic       px_cursor_en = 1'b0;
    logic [4:0] px_bits;
    logic       px_hit;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [64];
    bit done = 0;

    always #2.5 clk = ~clk;

    glyph_pattern_store dut_i (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .px_code      (px_code),
        .px_row       (px_row),
        .px_cursor_en (px_cursor_en),
        .px_bits      (px_bits),
        .px_hit       (px_hit)
    );

    task automatic cmp(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clr_model();
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model[a] = d;
    endtask

    task automatic chk_byte(input logic [5:0] a, input string tag);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
        cmp(rd_data, model[a], tag);
    endtask

    function automatic logic [4:0] exp_pix(input logic [7:0] c, input logic [2:0] r,
                                           input logic cur);
        logic [4:0] b;
        if (c >= 8'h10) return 5'h00;
        b = model[{c[2:0], r}][4:0];
        if (r == 3'd7 && cur) b = 5'h1F;
        return b;
    endfunction

    task automatic chk_pix(input logic [7:0] c, input logic [2:0] r, input logic cur,
                           input string tag);
        @(negedge clk);
        px_code = c; px_row = r; px_cursor_en = cur;
        @(negedge clk);
        cmp(px_bits, exp_pix(c, r, cur), {tag, " bits"});
        cmp(px_hit, (c < 8'h10), {tag, " hit"});
    endtask

    // R10: outputs after reset
    task automatic t_reset_state();
        cmp(rd_data, 0, "R10 rd_data after reset");
        cmp(px_bits, 0, "R10 px_bits after reset");
        cmp(px_hit, 0, "R10 px_hit after reset");
    endtask

    // R1: write several bytes, read them back in full
    task automatic t_byte_rw();
        do_write(6'd0, 8'hA5);
        do_write(6'd63, 8'h3C);
        do_write(6'd27, 8'hFF);
        chk_byte(6'd0, "R1 addr0");
        chk_byte(6'd63, "R1 addr63");
        chk_byte(6'd27, "R1 addr27");
        chk_byte(6'd5, "R1 unwritten");
    endtask

    // R2: same-cycle read returns old data, then new
    task automatic t_rdw();
        do_write(6'd12, 8'h11);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'd12; wr_data = 8'h22; rd_addr = 6'd12;
        @(negedge clk);
        wr_en = 1'b0;
        cmp(rd_data, 8'h11, "R2 old data during write");
        model[12] = 8'h22;
        @(negedge clk);
        cmp(rd_data, 8'h22, "R2 new data next cycle");
    endtask

    // R3: draw glyph 3 and read every row
    task automatic t_glyph_rows();
        for (int r = 0; r < 8; r++) do_write({3'd3, r[2:0]}, 8'(r * 3 + 1));
        for (int r = 0; r < 7; r++) chk_pix(8'h03, r[2:0], 1'b0, "R3 glyph3 row");
        do_write({3'd6, 3'd2}, 8'h0A);
        chk_pix(8'h06, 3'd2, 1'b0, "R3 glyph6 row2");
    endtask

    // R4: codes differing in bit 3 alias
    task automatic t_alias();
        for (int r = 0; r < 8; r++) do_write({3'd7, r[2:0]}, 8'(8'h10 + r * 5));
        for (int r = 0; r < 8; r++) chk_pix(8'h0F, r[2:0], 1'b0, "R4 code 0F");
        chk_pix(8'h07, 3'd4, 1'b0, "R4 code 07");
        chk_pix(8'h0B, 3'd1, 1'b0, "R4 code 0B");
    endtask

    // R5: hit boundary
    task automatic t_hit_range();
        chk_pix(8'h00, 3'd0, 1'b0, "R5 code 00");
        chk_pix(8'h10, 3'd0, 1'b0, "R5 code 10");
        chk_pix(8'h13, 3'd7, 1'b1, "R5 code 13 cursor");
        chk_pix(8'hFF, 3'd3, 1'b0, "R5 code FF");
        chk_pix(8'h80, 3'd0, 1'b0, "R5 code 80");
    endtask

    // R6 R7 R8: cursor line behaviour
    task automatic t_cursor();
        do_write({3'd2, 3'd7}, 8'h04);
        chk_pix(8'h02, 3'd7, 1'b0, "R7 stored bit only");
        chk_pix(8'h02, 3'd7, 1'b1, "R6 cursor full");
        chk_pix(8'h05, 3'd7, 1'b0, "R7 blank cursor row");
        chk_pix(8'h05, 3'd7, 1'b1, "R6 cursor blank glyph");
        chk_pix(8'h03, 3'd2, 1'b1, "R8 row2 cursor ignored");
        chk_pix(8'h03, 3'd6, 1'b1, "R8 row6 cursor ignored");
    endtask

    // R9: upper bits kept but not shown
    task automatic t_upper_bits();
        do_write({3'd1, 3'd0}, 8'hE0);
        do_write({3'd1, 3'd1}, 8'hB3);
        chk_pix(8'h01, 3'd0, 1'b0, "R9 upper bits only");
        chk_pix(8'h01, 3'd1, 1'b0, "R9 mixed byte");
        chk_byte({3'd1, 3'd0}, "R9 readback E0");
        chk_byte({3'd1, 3'd1}, "R9 readback B3");
    endtask

    // R10: reset clears store, write during reset dropped
    task automatic t_reset_clear();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; wr_addr = 6'd40; wr_data = 8'h5A;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
        clr_model();
        for (int i = 0; i < 64; i++) chk_byte(i[5:0], "R10 cleared byte");
        chk_pix(8'h07, 3'd7, 1'b0, "R10 blank glyph after reset");
    endtask

    initial begin
        clr_model();
        repeat (3) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        t_byte_rw();
        t_rdw();
        t_glyph_rows();
        t_alias();
        t_hit_range();
        t_cursor();
        t_upper_bits();
        t_reset_clear();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule